// File: doc/BRIEF.md
# Microframe Clock Reference Generator

This block produces the two time values that a streaming-video packetizer stamps into the clock-reference field of each payload header: a 32-bit source-time counter and an 11-bit bus frame number. Software configures three things: the reference clock frequency in MHz, the counter value that the first packet of a transfer should carry, and the frame number that packet should carry. Each step of the counter is one 125 µs microframe, so the step is 125 times the clock frequency in MHz.

The start values are kept already decremented by one step (counter) or by one (frame number). A transfer-start pulse loads these into the live counters. The first advance strobe then brings the live values to exactly the programmed start, and each later strobe moves them on by one microframe. Every advance also captures the value it produced, so the last stamp of a transfer stays readable after the transfer ends. Readback outputs give the step, the stored counter base, the requested counter start and the requested frame-number start.

Top module: `clkref_gen`

## Requirements
- R1: The step equals 125 × the programmed MHz value. After reset the MHz value is 30, so the step is 3750. A write shows on `step_o` one cycle after `mhz_we`.
- R2: The stored counter base `cnt_base_o` always equals the requested counter start minus the step, modulo 2^32. `cnt_start_rd` returns the requested start as written.
- R3: When the MHz value changes, the counter base is recomputed from the saved requested start, with no new write of the start value.
- R4: The stored frame base equals the written frame start minus one, modulo 2048. `frm_start_rd` returns the stored base plus one, masked to 11 bits. After reset it reads 0.
- R5: On an `advance` strobe the live counter `count_o` adds the step, modulo 2^32, one cycle later. The first advance after a transfer start yields exactly the requested counter start.
- R6: On each `advance` the frame number `frame_o` increments by one, modulo 2048. The first advance after a transfer start yields the requested frame start.
- R7: `xfer_start` loads the live counter and frame number from the stored bases one cycle later. If `advance` arrives in the same cycle, the reload wins and the advance has no effect.
- R8: Each accepted advance copies the new counter and frame values into `last_count_o` and `last_frame_o`. These hold through idle cycles and through a later reload.
- R9: After reset: live counter, frame number and last values are 0, the step is 3750, the counter base is 0xFFFFF15A and `cnt_start_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mhz_we | input | 1 | Write strobe for reference frequency |
| mhz_wdata | input | 8 | Reference frequency in MHz |
| cnt_start_we | input | 1 | Write strobe for counter start |
| cnt_start_wdata | input | 32 | Requested first counter value |
| frm_start_we | input | 1 | Write strobe for frame-number start |
| frm_start_wdata | input | 11 | Requested first frame number |
| xfer_start | input | 1 | Transfer start: reload live values from bases |
| advance | input | 1 | One packet emitted: step the live values |
| step_o | output | 32 | Current per-packet step |
| cnt_base_o | output | 32 | Stored counter base (start minus step) |
| cnt_start_rd | output | 32 | Requested counter start readback |
| frm_start_rd | output | 11 | Frame-number start readback |
| count_o | output | 32 | Live source-time counter |
| frame_o | output | 11 | Live frame number |
| last_count_o | output | 32 | Counter value of the last advance |
| last_frame_o | output | 11 | Frame number of the last advance |

## Verification
Every result is one register stage from its cause. A configuration write shows on the readbacks one cycle later. A reload or advance shows on the live and last outputs one cycle later. A reload reads the bases as they stood before that edge, so a write and a reload in the same cycle use the old base. The bench drives each stimulus for a single edge and samples 1 ns after that edge. Its reference model applies the update for that edge, taking every "old" value first, and only then compares all outputs.

// File: rtl/clkref_pkg.sv
package clkref_pkg;
    localparam int CNT_W_DEF   = 32;
    localparam int FRM_W_DEF   = 11;
    localparam int MHZ_W_DEF   = 8;
    localparam int STEP_MUL    = 125;
    localparam int MHZ_RST_DEF = 30;
endpackage

// File: rtl/clkref_cfg.sv
module clkref_cfg
    import clkref_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int FRM_W   = FRM_W_DEF,
    parameter int MHZ_W   = MHZ_W_DEF,
    parameter int MHZ_RST = MHZ_RST_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mhz_we,
    input  logic [MHZ_W-1:0] mhz_wdata,
    input  logic             cnt_start_we,
    input  logic [CNT_W-1:0] cnt_start_wdata,
    input  logic             frm_start_we,
    input  logic [FRM_W-1:0] frm_start_wdata,
    output logic [CNT_W-1:0] step,
    output logic [CNT_W-1:0] cnt_base,
    output logic [CNT_W-1:0] cnt_req,
    output logic [FRM_W-1:0] frm_base
);
    localparam logic [CNT_W-1:0] MUL_C    = CNT_W'(STEP_MUL);
    localparam logic [CNT_W-1:0] STEP_RST = MUL_C * CNT_W'(MHZ_RST);

    typedef struct packed {
        logic [MHZ_W-1:0] mhz;
        logic [CNT_W-1:0] req;
        logic [CNT_W-1:0] step;
        logic [CNT_W-1:0] base;
        logic [FRM_W-1:0] fbase;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mhz_we)       cfg_d.mhz   = mhz_wdata;
        if (cnt_start_we) cfg_d.req   = cnt_start_wdata;
        if (frm_start_we) cfg_d.fbase = frm_start_wdata - FRM_W'(1);
        cfg_d.step = MUL_C * CNT_W'(cfg_d.mhz);
        cfg_d.base = cfg_d.req - cfg_d.step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mhz   <= MHZ_W'(MHZ_RST);
            cfg_q.req   <= '0;
            cfg_q.step  <= STEP_RST;
            cfg_q.base  <= '0 - STEP_RST;
            cfg_q.fbase <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign step     = cfg_q.step;
    assign cnt_base = cfg_q.base;
    assign cnt_req  = cfg_q.req;
    assign frm_base = cfg_q.fbase;

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mhz_we |=> step == MUL_C * CNT_W'($past(mhz_wdata)));

    assert_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_base + step == cnt_req);

    assert_rebase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mhz_we && !cnt_start_we) |=> cnt_req == $past(cnt_req));

    assert_fbase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start_we |=> FRM_W'(frm_base + FRM_W'(1)) == $past(frm_start_wdata));
endmodule

// File: rtl/clkref_live.sv
module clkref_live
    import clkref_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int FRM_W = FRM_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             advance,
    input  logic [CNT_W-1:0] step,
    input  logic [CNT_W-1:0] cnt_base,
    input  logic [FRM_W-1:0] frm_base,
    output logic [CNT_W-1:0] count,
    output logic [FRM_W-1:0] frame,
    output logic [CNT_W-1:0] last_count,
    output logic [FRM_W-1:0] last_frame
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [FRM_W-1:0] frm;
        logic [CNT_W-1:0] lcnt;
        logic [FRM_W-1:0] lfrm;
    } live_t;

    live_t live_d, live_q;
    logic  take_adv;

    assign take_adv = advance && !reload;

    always_comb begin
        live_d = live_q;
        if (reload) begin
            live_d.cnt = cnt_base;
            live_d.frm = frm_base;
        end else if (take_adv) begin
            live_d.cnt  = live_q.cnt + step;
            live_d.frm  = live_q.frm + FRM_W'(1);
            live_d.lcnt = live_d.cnt;
            live_d.lfrm = live_d.frm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    assign count      = live_q.cnt;
    assign frame      = live_q.frm;
    assign last_count = live_q.lcnt;
    assign last_frame = live_q.lfrm;

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !reload) |=> count == $past(count) + $past(step));

    assert_frm_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !reload) |=> frame == FRM_W'($past(frame) + FRM_W'(1)));

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == $past(cnt_base)) && (frame == $past(frm_base)));

    assert_last_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !reload) |=> (last_count == count) && (last_frame == frame));

    assert_last_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance && !reload) |=> $stable(last_count) && $stable(last_frame));
endmodule

// File: rtl/clkref_gen.sv
module clkref_gen
    import clkref_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int FRM_W   = FRM_W_DEF,
    parameter int MHZ_W   = MHZ_W_DEF,
    parameter int MHZ_RST = MHZ_RST_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mhz_we,
    input  logic [MHZ_W-1:0] mhz_wdata,
    input  logic             cnt_start_we,
    input  logic [CNT_W-1:0] cnt_start_wdata,
    input  logic             frm_start_we,
    input  logic [FRM_W-1:0] frm_start_wdata,
    input  logic             xfer_start,
    input  logic             advance,
    output logic [CNT_W-1:0] step_o,
    output logic [CNT_W-1:0] cnt_base_o,
    output logic [CNT_W-1:0] cnt_start_rd,
    output logic [FRM_W-1:0] frm_start_rd,
    output logic [CNT_W-1:0] count_o,
    output logic [FRM_W-1:0] frame_o,
    output logic [CNT_W-1:0] last_count_o,
    output logic [FRM_W-1:0] last_frame_o
);
    logic [FRM_W-1:0] frm_base;

    clkref_cfg #(
        .CNT_W(CNT_W), .FRM_W(FRM_W), .MHZ_W(MHZ_W), .MHZ_RST(MHZ_RST)
    ) u_cfg (
        .clk             (clk),
        .rst_n           (rst_n),
        .mhz_we          (mhz_we),
        .mhz_wdata       (mhz_wdata),
        .cnt_start_we    (cnt_start_we),
        .cnt_start_wdata (cnt_start_wdata),
        .frm_start_we    (frm_start_we),
        .frm_start_wdata (frm_start_wdata),
        .step            (step_o),
        .cnt_base        (cnt_base_o),
        .cnt_req         (cnt_start_rd),
        .frm_base        (frm_base)
    );

    clkref_live #(
        .CNT_W(CNT_W), .FRM_W(FRM_W)
    ) u_live (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (xfer_start),
        .advance    (advance),
        .step       (step_o),
        .cnt_base   (cnt_base_o),
        .frm_base   (frm_base),
        .count      (count_o),
        .frame      (frame_o),
        .last_count (last_count_o),
        .last_frame (last_frame_o)
    );

    assign frm_start_rd = frm_base + FRM_W'(1);
endmodule

// File: tb/tb_clkref_gen.sv
`timescale 1ns/1ps
module tb_clkref_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mhz_we = 1'b0;
    logic [7:0]  mhz_wdata = '0;
    logic        cnt_start_we = 1'b0;
    logic [31:0] cnt_start_wdata = '0;
    logic        frm_start_we = 1'b0;
    logic [10:0] frm_start_wdata = '0;
    logic        xfer_start = 1'b0;
    logic        advance = 1'b0;
    logic [31:0] step_o, cnt_base_o, cnt_start_rd, count_o, last_count_o;
    logic [10:0] frm_start_rd, frame_o, last_frame_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0]  m_mhz;
    logic [31:0] m_req, m_cnt, m_lc;
    logic [10:0] m_fbase, m_frm, m_lf;

    always #2 clk = ~clk;

    clkref_gen dut (
        .clk(clk), .rst_n(rst_n),
        .mhz_we(mhz_we), .mhz_wdata(mhz_wdata),
        .cnt_start_we(cnt_start_we), .cnt_start_wdata(cnt_start_wdata),
        .frm_start_we(frm_start_we), .frm_start_wdata(frm_start_wdata),
        .xfer_start(xfer_start), .advance(advance),
        .step_o(step_o), .cnt_base_o(cnt_base_o), .cnt_start_rd(cnt_start_rd),
        .frm_start_rd(frm_start_rd), .count_o(count_o), .frame_o(frame_o),
        .last_count_o(last_count_o), .last_frame_o(last_frame_o)
    );

    function automatic logic [31:0] f_step(input logic [7:0] mhz);
        return 32'd125 * {24'd0, mhz};
    endfunction

    function automatic logic [31:0] f_base(input logic [31:0] req, input logic [7:0] mhz);
        return req - f_step(mhz);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all();
        chk("R1 step", step_o, f_step(m_mhz));
        chk("R2 R3 cnt_base", cnt_base_o, f_base(m_req, m_mhz));
        chk("R2 cnt_start_rd", cnt_start_rd, m_req);
        chk("R4 frm_start_rd", {21'd0, frm_start_rd}, {21'd0, 11'(m_fbase + 11'd1)});
        chk("R5 R7 count", count_o, m_cnt);
        chk("R6 R7 frame", {21'd0, frame_o}, {21'd0, m_frm});
        chk("R8 last_count", last_count_o, m_lc);
        chk("R8 last_frame", {21'd0, last_frame_o}, {21'd0, m_lf});
    endtask

    // one clock edge with given inputs; model updated with pre-edge values
    task automatic cyc(input logic mw, input logic [7:0] md,
                       input logic cw, input logic [31:0] cd,
                       input logic fw, input logic [10:0] fd,
                       input logic xs, input logic adv);
        logic [31:0] old_base, old_step;
        logic [10:0] old_fbase;
        mhz_we = mw; mhz_wdata = md;
        cnt_start_we = cw; cnt_start_wdata = cd;
        frm_start_we = fw; frm_start_wdata = fd;
        xfer_start = xs; advance = adv;
        @(posedge clk);
        #1;
        old_base  = f_base(m_req, m_mhz);
        old_step  = f_step(m_mhz);
        old_fbase = m_fbase;
        if (mw) m_mhz = md;
        if (cw) m_req = cd;
        if (fw) m_fbase = fd - 11'd1;
        if (xs) begin
            m_cnt = old_base;
            m_frm = old_fbase;
        end else if (adv) begin
            m_cnt = m_cnt + old_step;
            m_frm = m_frm + 11'd1;
            m_lc  = m_cnt;
            m_lf  = m_frm;
        end
        chk_all();
        mhz_we = 1'b0; cnt_start_we = 1'b0; frm_start_we = 1'b0;
        xfer_start = 1'b0; advance = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        m_mhz = 8'd30; m_req = '0; m_fbase = 11'h7FF;
        m_cnt = '0; m_frm = '0; m_lc = '0; m_lf = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 reset state
        chk("R9 step reset", step_o, 32'd3750);
        chk("R9 base reset", cnt_base_o, 32'hFFFF_F15A);
        chk("R9 start rd reset", cnt_start_rd, 32'd0);
        chk("R9 frame start rd reset", {21'd0, frm_start_rd}, 32'd0);
        chk("R9 count reset", count_o, 32'd0);
        chk("R9 last reset", last_count_o, 32'd0);

        // R5: default first advance yields requested start 0
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R5 first advance is start", count_o, 32'd0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R5 second advance", count_o, 32'd3750);

        // R3: MHz change rebases from saved start without new start write
        cyc(0, 0, 1, 32'd100000, 0, 0, 0, 0);
        cyc(1, 8'd48, 0, 0, 0, 0, 0, 0);
        chk("R3 rebase after MHz change", cnt_base_o, 32'd100000 - 32'd6000);

        // R5 wrap modulo 2^32, R6 frame wrap at 2047
        cyc(0, 0, 1, 32'hFFFF_FF00, 1, 11'd2047, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R6 first frame is start", {21'd0, frame_o}, 32'd2047);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R5 counter wrap", count_o, 32'hFFFF_FF00 + 32'd6000);
        chk("R6 frame wrap", {21'd0, frame_o}, 32'd0);

        // R4: frame start 0 stored as 0x7FF, reads back 0
        cyc(0, 0, 0, 0, 1, 11'd0, 0, 0);
        chk("R4 frame start 0 readback", {21'd0, frm_start_rd}, 32'd0);

        // R7: reload together with advance, reload wins; R8 last held
        cyc(0, 0, 0, 0, 0, 0, 1, 1);
        chk("R7 reload wins over advance", count_o, 32'hFFFF_FF00 - 32'd6000);
        chk("R8 last held over reload", last_count_o, 32'hFFFF_FF00 + 32'd6000);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            cyc(r < 8'd8, 8'($urandom_range(255, 1)),
                r > 8'd248, (r[0] ? 32'($urandom) : 32'hFFFF_FFF0),
                (r > 8'd10 && r < 8'd18), 11'($urandom),
                ($urandom_range(15, 0) == 0), ($urandom_range(2, 0) != 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule